// File: doc/BRIEF.md
# Multi-Size Quasi-Cyclic Lane Rotator

This block rotates the low Z lanes of a wide message vector by a run-time shift amount, as needed when quasi-cyclic LDPC decoding routes messages between a check-node group and a circulant sub-block. The rotation size Z is picked per transfer from two small codes: a base code that selects an odd-or-two factor, and an exponent that scales it by a power of two. Every product of the form a·2^j that fits within the maximum lane count is a legal size, which gives 51 sizes for the default width of 384 lanes.

One shared network serves every size. Each shift is split into a fine remainder below the power-of-two granularity G = 2^j of the selected size and a coarse multiple of G. A pre-rotator first folds the active lanes into a doubled window and moves it by the fine part. A logarithmic main rotator then moves it by the coarse part and trims the result back to Z lanes. Lanes at or above Z are always cleared on the output. A shift of Z or more is either reduced modulo Z or reported as an error, depending on a parameter. The result is registered once and marked valid one clock after the request.

Top module: `qc_multisize_shifter`

## Requirements
- R1: The base code selects a = 2 for code 0 and a = 2·code+1 for codes 1 to 7 (giving 3, 5, 7, 9, 11, 13, 15). The size is Z = a·2^exp. Exactly the 51 code/exponent pairs with Z ≤ MAX_Z (384) are accepted without error.
- R2: For a legal Z and a shift s < Z, output lane i (bits [i·LANE_W +: LANE_W]) equals input lane (i+s) mod Z for every i < Z. This holds for s = 1, s = Z−1 and arbitrary s.
- R3: Output lanes at or above Z are zero, and input lanes at or above Z have no effect on the output.
- R4: A shift of zero returns the low Z input lanes unchanged.
- R5: With REDUCE_MOD = 1, a shift s ≥ Z rotates by s mod Z, and out_err stays low.
- R6: With REDUCE_MOD = 0, a shift s ≥ Z sets out_err to 1 and clears out_data.
- R7: A code/exponent pair with Z > MAX_Z sets out_err to 1 and clears out_data in both modes.
- R8: A request taken with in_valid high appears on out_valid, out_err and out_data one rising edge later. In a cycle without in_valid, out_valid is low and out_data and out_err hold their previous values.
- R9: While rst_n is low, out_valid, out_err and out_data are zero. After rst_n rises, the first request accepted is the one present at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Request strobe; also the clock enable of the output register |
| in_data | input | MAX_Z·LANE_W | Lane vector; lane i occupies bits [i·LANE_W +: LANE_W] |
| in_base_sel | input | 3 | Base factor code (R1) |
| in_exp | input | J_W | Power-of-two exponent j of the size |
| in_shift | input | SHIFT_W | Requested rotation amount |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_err | output | 1 | Illegal size, or overshift when reduction is off |
| out_data | output | MAX_Z·LANE_W | Rotated vector, lanes at or above Z zero |

## Verification
The hardest case to reach is a shift whose fine and coarse parts both carry into the wrapped half of the doubled window while the size is small and odd-factored, so that a wrong fold position damages only one or two lanes. The stimulus walks every base code and exponent pair and applies shifts of 0, 1 and Z−1, random shifts below Z, and a random shift at or above Z. Random data is also placed in the unused upper lanes, so any leakage past Z shows up. Two instances, one per overshift mode, run on the same stimulus, and a reset-release sequence probes the acceptance edge.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  localparam int BASE_SEL_W = 3;
  localparam int BASE_VAL_W = 4;

  // Base factor: code 0 -> 2, code k>0 -> 2k+1
  function automatic logic [BASE_VAL_W-1:0] base_factor(input logic [BASE_SEL_W-1:0] sel);
    logic [BASE_VAL_W-1:0] b;
    if (sel == '0) b = BASE_VAL_W'(2);
    else           b = {sel, 1'b1};
    return b;
  endfunction
endpackage

// File: rtl/qcs_reset_sync.sv
module qcs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/qcs_size_decode.sv
module qcs_size_decode #(
  parameter int MAX_Z = 384,
  parameter int J_W   = 3,
  parameter int ZW    = 9
) (
  input  logic [qcs_pkg::BASE_SEL_W-1:0] base_sel,
  input  logic [J_W-1:0]                 exp_sel,
  output logic [ZW-1:0]                  size_z,
  output logic                           size_ok
);
  localparam int PW = qcs_pkg::BASE_VAL_W + (2**J_W);

  logic [PW-1:0] product;

  always_comb begin
    product = PW'(qcs_pkg::base_factor(base_sel)) << exp_sel;
    size_ok = (product <= PW'(MAX_Z));
    size_z  = size_ok ? product[ZW-1:0] : '0;
  end
endmodule

// File: rtl/qcs_pre_rotator.sv
// Fine stage: folds the active lanes into a doubled window, then moves it
// toward lane 0 by the fine remainder (below the size granularity).
module qcs_pre_rotator #(
  parameter int MAX_Z  = 384,
  parameter int LANE_W = 8,
  parameter int ZW     = 9,
  parameter int FB     = 7
) (
  input  logic [MAX_Z*LANE_W-1:0]   lanes_in,
  input  logic [ZW-1:0]             size_z,
  input  logic [FB-1:0]             fine_amt,
  output logic [2*MAX_Z*LANE_W-1:0] window_out
);
  localparam int VW = MAX_Z * LANE_W;
  localparam int EW = 2 * VW;

  logic [VW-1:0] active;
  logic [EW-1:0] fold [ZW+1];
  logic [EW-1:0] fine [FB+1];

  // Clear lanes at or above the selected size
  for (genvar l = 0; l < MAX_Z; l++) begin : g_mask
    assign active[l*LANE_W +: LANE_W] =
      (ZW'(l) < size_z) ? lanes_in[l*LANE_W +: LANE_W] : '0;
  end

  // Second copy placed Z lanes up: window lane k = active lane (k mod Z), k < 2Z
  assign fold[0] = {{VW{1'b0}}, active};
  for (genvar k = 0; k < ZW; k++) begin : g_fold
    localparam int SH = LANE_W * (2**k);
    assign fold[k+1] = size_z[k] ? (fold[k] << SH) : fold[k];
  end

  assign fine[0] = fold[0] | fold[ZW];
  for (genvar k = 0; k < FB; k++) begin : g_fine
    localparam int SH = LANE_W * (2**k);
    assign fine[k+1] = fine_amt[k] ? (fine[k] >> SH) : fine[k];
  end

  assign window_out = fine[FB];
endmodule

// File: rtl/qcs_main_rotator.sv
// Coarse stage: logarithmic shifter, routing only toward lower lanes,
// moving the window by the coarse multiple and trimming to Z lanes.
module qcs_main_rotator #(
  parameter int MAX_Z  = 384,
  parameter int LANE_W = 8,
  parameter int ZW     = 9
) (
  input  logic [2*MAX_Z*LANE_W-1:0] window_in,
  input  logic [ZW-1:0]             size_z,
  input  logic [ZW-1:0]             coarse_amt,
  output logic [MAX_Z*LANE_W-1:0]   lanes_out
);
  localparam int VW = MAX_Z * LANE_W;
  localparam int EW = 2 * VW;

  logic [EW-1:0] stage [ZW+1];

  assign stage[0] = window_in;
  for (genvar k = 0; k < ZW; k++) begin : g_coarse
    localparam int SH = LANE_W * (2**k);
    assign stage[k+1] = coarse_amt[k] ? (stage[k] >> SH) : stage[k];
  end

  for (genvar l = 0; l < MAX_Z; l++) begin : g_trim
    assign lanes_out[l*LANE_W +: LANE_W] =
      (ZW'(l) < size_z) ? stage[ZW][l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/qc_multisize_shifter.sv
module qc_multisize_shifter #(
  parameter int MAX_Z      = 384,
  parameter int LANE_W     = 8,
  parameter int J_W        = 3,
  parameter int SHIFT_W    = 9,
  parameter bit REDUCE_MOD = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [MAX_Z*LANE_W-1:0]        in_data,
  input  logic [qcs_pkg::BASE_SEL_W-1:0] in_base_sel,
  input  logic [J_W-1:0]                 in_exp,
  input  logic [SHIFT_W-1:0]             in_shift,
  output logic                           out_valid,
  output logic                           out_err,
  output logic [MAX_Z*LANE_W-1:0]        out_data
);
  localparam int VW   = MAX_Z * LANE_W;
  localparam int ZW   = $clog2(MAX_Z + 1);
  localparam int CW   = (SHIFT_W > ZW) ? SHIFT_W : ZW;
  localparam int JMAX = (2**J_W) - 1;
  localparam int FB   = (JMAX < ZW) ? JMAX : ZW;

  logic          rst_sync_n;
  logic [ZW-1:0] size_z;
  logic          size_ok;
  logic [CW-1:0] shift_w;
  logic [CW-1:0] size_w;
  logic [CW-1:0] shift_mod;
  logic          overshift;
  logic [ZW-1:0] shift_eff;
  logic [ZW-1:0] fine_mask;
  logic [FB-1:0] fine_amt;
  logic [ZW-1:0] coarse_amt;
  logic [2*VW-1:0] window;
  logic [VW-1:0] rotated;

  logic          valid_d, err_d;
  logic [VW-1:0] data_d;
  logic          valid_q, err_q;
  logic [VW-1:0] data_q;

  qcs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qcs_size_decode #(.MAX_Z(MAX_Z), .J_W(J_W), .ZW(ZW)) u_size (
    .base_sel (in_base_sel),
    .exp_sel  (in_exp),
    .size_z   (size_z),
    .size_ok  (size_ok)
  );

  // Shift reduction and fine/coarse split: s = c*2^j + f, f < 2^j
  always_comb begin
    shift_w    = CW'(in_shift);
    size_w     = CW'(size_z);
    overshift  = (shift_w >= size_w);
    shift_mod  = (size_w != '0) ? (shift_w % size_w) : '0;
    if (REDUCE_MOD)     shift_eff = ZW'(shift_mod);
    else if (overshift) shift_eff = '0;
    else                shift_eff = ZW'(shift_w);
    fine_mask  = ~({ZW{1'b1}} << in_exp);
    fine_amt   = shift_eff[FB-1:0] & fine_mask[FB-1:0];
    coarse_amt = shift_eff & ~fine_mask;
  end

  qcs_pre_rotator #(.MAX_Z(MAX_Z), .LANE_W(LANE_W), .ZW(ZW), .FB(FB)) u_fine (
    .lanes_in   (in_data),
    .size_z     (size_z),
    .fine_amt   (fine_amt),
    .window_out (window)
  );

  qcs_main_rotator #(.MAX_Z(MAX_Z), .LANE_W(LANE_W), .ZW(ZW)) u_coarse (
    .window_in  (window),
    .size_z     (size_z),
    .coarse_amt (coarse_amt),
    .lanes_out  (rotated)
  );

  // Next-state logic for the output stage
  always_comb begin
    valid_d = in_valid;
    err_d   = !size_ok || (!REDUCE_MOD && overshift);
    data_d  = err_d ? '0 : rotated;
  end

  // Output register, in_valid acts as clock enable for data and error
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        err_q  <= err_d;
        data_q <= data_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_data  = data_q;
endmodule

// File: rtl/qcs_checker.sv
module qcs_checker #(
  parameter int MAX_Z      = 384,
  parameter int LANE_W     = 8,
  parameter int J_W        = 3,
  parameter int SHIFT_W    = 9,
  parameter bit REDUCE_MOD = 1'b1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [MAX_Z*LANE_W-1:0]        in_data,
  input logic [qcs_pkg::BASE_SEL_W-1:0] in_base_sel,
  input logic [J_W-1:0]                 in_exp,
  input logic [SHIFT_W-1:0]             in_shift,
  input logic                           out_valid,
  input logic                           out_err,
  input logic [MAX_Z*LANE_W-1:0]        out_data
);
  localparam int VW = MAX_Z * LANE_W;

  function automatic int size_of(input logic [qcs_pkg::BASE_SEL_W-1:0] sel,
                                 input logic [J_W-1:0] e);
    int b;
    b = (sel == '0) ? 2 : (2 * int'(sel) + 1);
    return b << e;
  endfunction

  function automatic logic [VW-1:0] low_lanes(input int z);
    logic [VW-1:0] m;
    m = '0;
    for (int l = 0; l < MAX_Z; l++)
      if (l < z) m[l*LANE_W +: LANE_W] = '1;
    return m;
  endfunction

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_err && out_data == '0));

  assert_valid_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_err)));

  assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_of(in_base_sel, in_exp) > MAX_Z)
    |=> (!out_valid || (out_err && out_data == '0)));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err)
    |-> ((out_data & ~low_lanes(size_of($past(in_base_sel), $past(in_exp)))) == '0));

  assert_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift == '0 && size_of(in_base_sel, in_exp) <= MAX_Z)
    |=> (!out_valid || (!out_err &&
         out_data == ($past(in_data) & low_lanes(size_of($past(in_base_sel), $past(in_exp)))))));

  assert_reduce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (REDUCE_MOD && in_valid && size_of(in_base_sel, in_exp) <= MAX_Z &&
     int'(in_shift) >= size_of(in_base_sel, in_exp))
    |=> (!out_valid || !out_err));

  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!REDUCE_MOD && in_valid && size_of(in_base_sel, in_exp) <= MAX_Z &&
     int'(in_shift) >= size_of(in_base_sel, in_exp))
    |=> (!out_valid || (out_err && out_data == '0)));
endmodule

bind qc_multisize_shifter qcs_checker #(
  .MAX_Z(MAX_Z), .LANE_W(LANE_W), .J_W(J_W), .SHIFT_W(SHIFT_W), .REDUCE_MOD(REDUCE_MOD)
) chk_i (.*);

// File: tb/qc_multisize_shifter_tb.sv
module qc_multisize_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_Z   = 384;
  localparam int LW      = 8;
  localparam int J_W     = 3;
  localparam int SHIFT_W = 9;
  localparam int VW      = MAX_Z * LW;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [VW-1:0]      in_data;
  logic [2:0]         in_base_sel;
  logic [J_W-1:0]     in_exp;
  logic [SHIFT_W-1:0] in_shift;
  logic               out_valid, out_err;
  logic [VW-1:0]      out_data;
  logic               fl_valid, fl_err;
  logic [VW-1:0]      fl_data;

  int checks = 0;
  int fails  = 0;

  qc_multisize_shifter #(.MAX_Z(MAX_Z), .LANE_W(LW), .J_W(J_W), .SHIFT_W(SHIFT_W),
                         .REDUCE_MOD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_base_sel(in_base_sel), .in_exp(in_exp), .in_shift(in_shift),
    .out_valid(out_valid), .out_err(out_err), .out_data(out_data));

  qc_multisize_shifter #(.MAX_Z(MAX_Z), .LANE_W(LW), .J_W(J_W), .SHIFT_W(SHIFT_W),
                         .REDUCE_MOD(1'b0)) dut_flag_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_base_sel(in_base_sel), .in_exp(in_exp), .in_shift(in_shift),
    .out_valid(fl_valid), .out_err(fl_err), .out_data(fl_data));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int base_of(input int sel);
    return (sel == 0) ? 2 : 2 * sel + 1;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int l = 0; l < MAX_Z; l++) v[l*LW +: LW] = LW'($urandom);
    return v;
  endfunction

  function automatic logic [VW-1:0] ref_rot(input logic [VW-1:0] d, input int z, input int s);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < z; i++) r[i*LW +: LW] = d[((i + s) % z)*LW +: LW];
    return r;
  endfunction

  function automatic int first_diff(input logic [VW-1:0] a, input logic [VW-1:0] b);
    for (int l = 0; l < MAX_Z; l++)
      if (a[l*LW +: LW] !== b[l*LW +: LW]) return l;
    return -1;
  endfunction

  task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    int d;
    checks++;
    d = first_diff(act, exp);
    if (d >= 0) begin
      fails++;
      $display("FAIL %s: lane %0d actual=%h expected=%h", tag, d,
               act[d*LW +: LW], exp[d*LW +: LW]);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int sel, input int e, input int s, input logic [VW-1:0] d);
    @(negedge clk);
    in_base_sel = 3'(sel);
    in_exp      = J_W'(e);
    in_shift    = SHIFT_W'(s);
    in_data     = d;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid    = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R8: watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] d;
    logic [VW-1:0] held;
    int z, s, legal;
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    in_valid = 1'b0; in_data = '0; in_base_sel = '0; in_exp = '0; in_shift = '0;
    #1 rst_n = 1'b0;

    // R9: reset state, then acceptance on the third edge after release
    in_valid = 1'b1; in_base_sel = 3'd0; in_exp = J_W'(2); in_shift = SHIFT_W'(3);
    d = rand_vec(); in_data = d;
    repeat (3) @(negedge clk);
    check_int("R9 reset out_valid", int'(out_valid), 0);
    check_int("R9 reset out_err", int'(out_err), 0);
    check_vec("R9 reset out_data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_int("R9 not accepted at second edge", int'(out_valid), 0);
    @(negedge clk);
    check_int("R9 accepted at third edge", int'(out_valid), 1);
    check_vec("R9 first accepted result", out_data, ref_rot(d, 8, 3));
    in_valid = 1'b0;
    @(negedge clk);
    check_int("R8 valid drops without request", int'(out_valid), 0);

    legal = 0;
    for (int sel = 0; sel < 8; sel++) begin
      for (int e = 0; e < 8; e++) begin
        z = base_of(sel) << e;
        if (z > MAX_Z) begin
          apply(sel, e, int'($urandom % 512), rand_vec());
          check_int("R7 illegal size err", int'(out_err), 1);
          check_vec("R7 illegal size data", out_data, '0);
          check_int("R7 illegal size err flag mode", int'(fl_err), 1);
          check_vec("R7 illegal size data flag mode", fl_data, '0);
        end else begin
          for (int k = 0; k < 7; k++) begin
            if (k == 0)      s = 0;
            else if (k == 1) s = 1;
            else if (k == 2) s = z - 1;
            else if (k < 6)  s = int'($urandom % z);
            else             s = z + int'($urandom % (512 - z));
            d = rand_vec();
            apply(sel, e, s, d);
            if (k == 0) begin
              if (out_err == 1'b0) legal++;
              check_int("R8 out_valid one edge after request", int'(out_valid), 1);
              check_vec("R4 zero shift", out_data, ref_rot(d, z, 0));
              check_vec("R3 upper lanes zero", out_data & ~ref_rot({VW{1'b1}}, z, 0), '0);
            end else if (k < 6) begin
              check_vec("R2 rotation", out_data, ref_rot(d, z, s));
              check_vec("R2 rotation flag mode", fl_data, ref_rot(d, z, s));
              check_int("R2 no error", int'(out_err), 0);
            end else begin
              check_vec("R5 reduced overshift", out_data, ref_rot(d, z, s % z));
              check_int("R5 no error on overshift", int'(out_err), 0);
              check_int("R6 overshift flagged", int'(fl_err), 1);
              check_vec("R6 overshift data cleared", fl_data, '0);
            end
          end
          if (e == 1) begin
            held = out_data;
            in_data = rand_vec(); in_shift = SHIFT_W'($urandom % 512);
            @(negedge clk);
            check_int("R8 idle out_valid", int'(out_valid), 0);
            check_vec("R8 idle hold", out_data, held);
          end
        end
      end
    end
    check_int("R1 legal size count", legal, 51);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule